// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with PWM Pin Takeover

This block is an 8-bit bidirectional port on a small register bus with an address, a write strobe, write data and read data. Three registers control it: a per-pin direction mask, an output data latch, and a per-pin PWM takeover mask. For each pin it drives a value and an output-enable toward an external tri-state pad, and it takes in the level sampled on that pad. A PWM generator outside the block supplies eight channel lines. Any pin whose takeover bit is set is driven by its channel instead of by the port.

A read of the data offset is assembled bit by bit. An output pin returns its latch bit. An input pin returns its pad level after the level has passed through a two-flop synchronizer. Writes to the data offset always land in the latch. This means software can preload a value before it turns a pin into an output. Bus reads are combinational from the address. Writes take effect at the clock edge on which the strobe is high.

Top module: `gpio_ovr_port`

## Requirements
- R1: On reset the direction mask, data latch and takeover mask are all zero and every pad output-enable is 0.
- R2: The direction mask at offset 0x05 can be written and read back as a full 8-bit value; a bit of 1 makes that pin an output.
- R3: A pin with direction 1 and takeover 0 has output-enable 1, drives its latch bit, and returns its latch bit on a read of offset 0x01.
- R4: A pin with direction 0 and takeover 0 has output-enable 0 and returns its synchronized pad level on a read of offset 0x01.
- R5: A write to offset 0x01 updates the whole latch whatever the direction mask holds, and it does not change the read-back of input pins. The latch keeps its value until the next such write.
- R6: The takeover mask at offset 0x78 can be written and read back as a full 8-bit value.
- R7: A pin with takeover 1 has output-enable 1 and drives its PWM channel line, whatever its direction and latch bits hold. Neither the direction bit nor the latch bit is changed by the takeover.
- R8: A pad level change is first visible on a data read after the second rising clock edge, and it is not visible after only the first.
- R9: Reads of any offset other than 0x01, 0x05 and 0x78 return zero, and writes to such offsets change no register.
- R10: Direction, takeover and read-back are decided independently for each bit, so mixed masks give a per-bit mix of behaviours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 8 | Sampled pad levels (asynchronous) |
| pwm_line | input | 8 | PWM channel outputs, one per pin |
| pad_out | output | 8 | Value driven toward each pad |
| pad_oe | output | 8 | Output-enable for each pad |

## Verification
The assertions assume that bus_addr, bus_wr and bus_wdata are steady around each rising edge. They also assume that pad_in, although asynchronous in use, is sampled as a clean level at each edge. The synchronizer assertion only compares values older than two cycles once two cycles have passed since reset. The bench changes every input on the falling clock edge, holds the write strobe for exactly one rising edge, and samples results on the falling edge. This keeps every setup and sampling point a half period from the edges at which the registers move.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DATA = 8'h01;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 8'h05;
  localparam logic [ADDR_W-1:0] OFS_PWM  = 8'h78;

  typedef logic [PORT_W-1:0] port_vec_t;

  // Per-bit readback: latch where the pin is an output, synchronized pad otherwise.
  function automatic port_vec_t data_readback(port_vec_t dir, port_vec_t latch, port_vec_t pin);
    return (dir & latch) | (~dir & pin);
  endfunction

  // Per-bit pad value: PWM channel where taken over, latch otherwise.
  function automatic logic pad_value(logic take, logic pwm, logic latch);
    return take ? pwm : latch;
  endfunction

  // Per-bit output enable: driven when taken over or set as output.
  function automatic logic pad_enable(logic take, logic dir);
    return take | dir;
  endfunction
endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;

  // Cycles since reset, saturating, so the latency check never reaches before reset.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  assert_sync_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (d_sync == $past(d_async, 2)));
endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int W  = PORT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  latch_q,
  output logic [W-1:0]  take_q
);
  logic wr_dir_hit;
  logic wr_data_hit;
  logic wr_take_hit;

  assign wr_dir_hit  = wr && (addr == OFS_DIR);
  assign wr_data_hit = wr && (addr == OFS_DATA);
  assign wr_take_hit = wr && (addr == OFS_PWM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      latch_q <= '0;
      take_q  <= '0;
    end else begin
      if (wr_dir_hit)  dir_q   <= wdata;
      if (wr_data_hit) latch_q <= wdata;
      if (wr_take_hit) take_q  <= wdata;
    end
  end

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_DIR) |=> (dir_q == $past(wdata)));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == OFS_DATA) |=> $stable(latch_q));

  assert_take_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_PWM) |=> (take_q == $past(wdata)));

  assert_dir_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == OFS_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_ovr_pinmux.sv
module gpio_ovr_pinmux
  import gpio_ovr_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic [W-1:0] dir,
  input  logic [W-1:0] latch,
  input  logic [W-1:0] take,
  input  logic [W-1:0] pwm,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pad_out[i] = pad_value(take[i], pwm[i], latch[i]);
    assign pad_oe[i]  = pad_enable(take[i], dir[i]);
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pad_in,
  input  logic [PORT_W-1:0] pwm_line,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe
);
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] latch_q;
  logic [PORT_W-1:0] take_q;
  logic [PORT_W-1:0] pin_sync;
  logic [PORT_W-1:0] data_view;

  gpio_ovr_regs #(.W(PORT_W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .dir_q(dir_q), .latch_q(latch_q), .take_q(take_q)
  );

  gpio_ovr_sync #(.W(PORT_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pad_in), .d_sync(pin_sync)
  );

  gpio_ovr_pinmux #(.W(PORT_W)) u_mux (
    .dir(dir_q), .latch(latch_q), .take(take_q), .pwm(pwm_line),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign data_view = data_readback(dir_q, latch_q, pin_sync);

  always_comb begin
    case (bus_addr)
      OFS_DATA: bus_rdata = data_view;
      OFS_DIR:  bus_rdata = dir_q;
      OFS_PWM:  bus_rdata = take_q;
      default:  bus_rdata = '0;
    endcase
  end

  // An output pin that is not taken over must match the value last written to the data offset.
  logic [PORT_W-1:0] last_data_wr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_data_wr_q <= '0;
    else if (bus_wr && bus_addr == OFS_DATA) last_data_wr_q <= bus_wdata;
  end

  assert_out_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~take_q & pad_out) == (pad_oe & ~take_q & last_data_wr_q)));
endmodule

// File: tb/tb_gpio_ovr_port.sv
`timescale 1ns/1ps
module tb_gpio_ovr_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in;
  logic [7:0] pwm_line;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_DATA = 8'h01;
  localparam logic [7:0] A_DIR  = 8'h05;
  localparam logic [7:0] A_PWM  = 8'h78;

  always #2 clk = ~clk;

  gpio_ovr_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pwm_line(pwm_line), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  // Bench-side model of a data read, bit by bit.
  function automatic logic [7:0] model_read(logic [7:0] dir, logic [7:0] lat, logic [7:0] pin);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = dir[i] ? lat[i] : pin[i];
    return r;
  endfunction

  task automatic settle_pins(input logic [7:0] v);
    @(negedge clk); pad_in = v;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    rd_reg(A_DIR, r);  check("R1 dir after reset", r, 8'h00);
    rd_reg(A_PWM, r);  check("R1 take after reset", r, 8'h00);
    check("R1 oe after reset", pad_oe, 8'h00);
    wr_reg(A_DIR, 8'hFF);
    rd_reg(A_DATA, r); check("R1 latch after reset", r, 8'h00);
    wr_reg(A_DIR, 8'h00);
  endtask

  task automatic t_dir_rw();
    logic [7:0] r;
    wr_reg(A_DIR, 8'hA5); rd_reg(A_DIR, r); check("R2 dir A5", r, 8'hA5);
    wr_reg(A_DIR, 8'h5A); rd_reg(A_DIR, r); check("R2 dir 5A", r, 8'h5A);
    wr_reg(A_DIR, 8'h00);
  endtask

  task automatic t_output();
    logic [7:0] r;
    settle_pins(8'h00);
    wr_reg(A_DATA, 8'h3C);
    wr_reg(A_DIR, 8'hFF);
    check("R3 oe all out", pad_oe, 8'hFF);
    check("R3 pad_out latch", pad_out, 8'h3C);
    rd_reg(A_DATA, r); check("R3 read latch", r, 8'h3C);
  endtask

  task automatic t_input();
    logic [7:0] r;
    wr_reg(A_DIR, 8'h00);
    settle_pins(8'h96);
    check("R4 oe all in", pad_oe, 8'h00);
    rd_reg(A_DATA, r); check("R4 read pins", r, 8'h96);
  endtask

  task automatic t_write_input();
    logic [7:0] r;
    settle_pins(8'h0F);
    wr_reg(A_DATA, 8'hF0);
    rd_reg(A_DATA, r); check("R5 input readback unchanged", r, 8'h0F);
    wr_reg(A_DIR, 8'hFF);
    rd_reg(A_DATA, r); check("R5 latch took write", r, 8'hF0);
    check("R5 pad_out latch", pad_out, 8'hF0);
    wr_reg(A_DIR, 8'h00);
  endtask

  task automatic t_take_reg();
    logic [7:0] r;
    wr_reg(A_PWM, 8'hC3); rd_reg(A_PWM, r); check("R6 take C3", r, 8'hC3);
    wr_reg(A_PWM, 8'h00); rd_reg(A_PWM, r); check("R6 take 00", r, 8'h00);
  endtask

  task automatic t_takeover();
    logic [7:0] r;
    wr_reg(A_DATA, 8'h55);
    wr_reg(A_DIR, 8'h0F);
    pwm_line = 8'hA3;
    wr_reg(A_PWM, 8'hFF);
    check("R7 oe forced", pad_oe, 8'hFF);
    check("R7 pad from pwm", pad_out, 8'hA3);
    pwm_line = 8'h5C; #0.5;
    check("R7 pad follows pwm", pad_out, 8'h5C);
    rd_reg(A_DIR, r); check("R7 dir kept", r, 8'h0F);
    wr_reg(A_PWM, 8'h00);
    check("R7 latch kept on pad", pad_out & pad_oe, 8'h05);
    check("R7 oe back to dir", pad_oe, 8'h0F);
    wr_reg(A_DIR, 8'h00);
  endtask

  task automatic t_sync_latency();
    logic [7:0] r;
    wr_reg(A_DIR, 8'h00);
    settle_pins(8'h00);
    @(negedge clk); pad_in = 8'hE7;
    @(negedge clk);
    rd_reg(A_DATA, r); check("R8 not after one edge", r, 8'h00);
    @(negedge clk);
    rd_reg(A_DATA, r); check("R8 after two edges", r, 8'hE7);
  endtask

  task automatic t_unmapped();
    logic [7:0] r;
    wr_reg(A_DIR, 8'h12);
    wr_reg(A_PWM, 8'h00);
    rd_reg(8'h00, r); check("R9 read 00", r, 8'h00);
    rd_reg(8'h02, r); check("R9 read 02", r, 8'h00);
    rd_reg(8'hFF, r); check("R9 read FF", r, 8'h00);
    wr_reg(8'h06, 8'hFF);
    wr_reg(8'h79, 8'hFF);
    rd_reg(A_DIR, r); check("R9 dir untouched", r, 8'h12);
    rd_reg(A_PWM, r); check("R9 take untouched", r, 8'h00);
    wr_reg(A_DIR, 8'hFF);
    rd_reg(A_DATA, r); check("R9 latch untouched", r, 8'h55);
    wr_reg(A_DIR, 8'h00);
  endtask

  task automatic t_mixed();
    logic [7:0] r;
    logic [7:0] exp_out;
    settle_pins(8'hCA);
    wr_reg(A_DATA, 8'h6B);
    wr_reg(A_DIR, 8'hB1);
    rd_reg(A_DATA, r); check("R10 mixed read", r, model_read(8'hB1, 8'h6B, 8'hCA));
    pwm_line = 8'hFF;
    wr_reg(A_PWM, 8'h22);
    check("R10 mixed oe", pad_oe, 8'hB3);
    for (int i = 0; i < 8; i++) exp_out[i] = (i == 1 || i == 5) ? 1'b1 : ((8'h6B >> i) & 8'h01) != 0;
    check("R10 mixed pad_out", pad_out, exp_out);
    wr_reg(A_PWM, 8'h00);
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = 8'h00; bus_wr = 1'b0; bus_wdata = 8'h00;
    pad_in = 8'h00; pwm_line = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir_rw();
    t_output();
    t_input();
    t_write_input();
    t_take_reg();
    t_takeover();
    t_sync_latency();
    t_unmapped();
    t_mixed();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule